// File: doc/BRIEF.md
# Highest Priority Pending Selector

This block looks at every interrupt source wired to one processor and names the single source that should be signalled next. A source counts only when it is pending, individually enabled, and its group (one bit per source, two groups) is switched on. Its priority must also beat the processor's priority mask. Among the sources that count, the one with the numerically smallest priority wins, and the lower ID wins a tie. Priorities are eight-bit values, but only the upper `PRIO_BITS` bits take part in any comparison. The bits below them are treated as zero, so several raw values fall into one level.

Source index `i` is reported as ID `i`. The reported ID also carries a range kind: software-generated, private peripheral, or shared peripheral. When nothing qualifies, the block reports the reserved ID 1023 with its valid flag low. The result is registered, so each output reflects the inputs one clock edge earlier. Per-source eligibility is formed in a control module, and a binary compare tree in the datapath module reduces the sources.

Top module: `hpp_select`

## Requirements
- R1: While `rstN` is low and on the first cycle after it, the outputs are `outValid`=0, `outId`=1023, `outPrio`=0xFF and `outKind`=3, whatever the other inputs are.
- R2: Source i is a candidate only if `srcPending[i]`, `srcEnable[i]` and `grpEnable[srcGroup[i]]` are all 1. Group bit 0 selects `grpEnable[0]`, and group bit 1 selects `grpEnable[1]`.
- R3: Priorities and the mask are compared on their upper `PRIO_BITS` bits only (default 4). The lower bits are ignored, so raw 0x81 and 0x8F are the same level.
- R4: Among candidates, the one with the smallest truncated priority is reported.
- R5: When truncated priorities are equal, the lowest ID is reported.
- R6: A source is a candidate only if its truncated priority is strictly less than the truncated `prioMask`. An equal level is not enough.
- R7: With no candidate, the outputs are `outValid`=0, `outId`=1023, `outPrio`=0xFF and `outKind`=3.
- R8: `outKind` is 0 for IDs 0–15, 1 for IDs 16–31 and 2 for IDs 32 and above. The value 3 means none.
- R9: The outputs change on the clock edge that follows an input change, and not before it.
- R10: `outPrio` reports the winner's truncated priority, with the bits below the implemented ones at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcPending | input | NUM_SRC | Pending flag per source |
| srcEnable | input | NUM_SRC | Enable flag per source |
| srcGroup | input | NUM_SRC | Group bit per source |
| srcPrio | input | NUM_SRC*8 | Eight-bit priority per source; source i at bits [8i+7:8i] |
| grpEnable | input | 2 | Enable for group 0 (bit 0) and group 1 (bit 1) |
| prioMask | input | 8 | Processor priority mask |
| outValid | output | 1 | A candidate exists |
| outId | output | 10 | Winning ID, or 1023 when none |
| outPrio | output | 8 | Truncated priority of the winner, or 0xFF when none |
| outKind | output | 2 | ID range kind of the winner |

## Verification
The hardest situations to reach from the ports are those where truncation changes the answer. One is a higher ID whose raw priority is smaller but lands on the same level as a lower ID. The other is a mask whose raw value exceeds the source's priority while sitting on the same truncated level. Directed cases set exactly those raw values on a few pending sources against a background of disabled high values. A fixed table of mixed pending, enable, group and mask patterns is then run against a linear-scan reference model in the bench. A latency probe looks just after an input change and again after the next edge.

// File: rtl/hpp_pkg.sv
package hpp_pkg;
  localparam int PRIO_W = 8;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NONE_ID = ID_W'(1023);

  typedef enum logic [1:0] {
    KIND_SGI  = 2'd0,
    KIND_PPI  = 2'd1,
    KIND_SPI  = 2'd2,
    KIND_NONE = 2'd3
  } kind_e;

  typedef struct packed {
    logic anyHit;
    logic primed;
  } strobe_t;

  typedef struct packed {
    logic              vld;
    logic [PRIO_W-1:0] pr;
    logic [ID_W-1:0]   id;
  } cand_t;

  function automatic kind_e kindOf(logic [ID_W-1:0] id);
    if (id < ID_W'(16)) return KIND_SGI;
    else if (id < ID_W'(32)) return KIND_PPI;
    else return KIND_SPI;
  endfunction

  function automatic cand_t pickBetter(cand_t a, cand_t b);
    if (a.vld && (!b.vld || a.pr <= b.pr)) return a;
    else return b;
  endfunction
endpackage

// File: rtl/hpp_ctrl.sv
module hpp_ctrl
  import hpp_pkg::*;
#(
  parameter int NUM_SRC   = 64,
  parameter int PRIO_BITS = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        srcPending,
  input  logic [NUM_SRC-1:0]        srcEnable,
  input  logic [NUM_SRC-1:0]        srcGroup,
  input  logic [NUM_SRC*PRIO_W-1:0] srcPrio,
  input  logic [1:0]                grpEnable,
  input  logic [PRIO_W-1:0]         prioMask,
  output logic [NUM_SRC-1:0]        eligible,
  output logic [NUM_SRC*PRIO_W-1:0] levelPrio,
  output strobe_t                   strobe
);
  localparam logic [PRIO_W-1:0] KEEP = PRIO_W'(8'hFF << (PRIO_W - PRIO_BITS));

  logic [PRIO_W-1:0] maskLvl;
  logic primed;

  assign maskLvl = prioMask & KEEP;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [PRIO_W-1:0] lvl;
    assign lvl = srcPrio[i*PRIO_W +: PRIO_W] & KEEP;
    assign levelPrio[i*PRIO_W +: PRIO_W] = lvl;
    assign eligible[i] = srcPending[i] & srcEnable[i]
                       & grpEnable[srcGroup[i]] & (lvl < maskLvl);
  end

  always_ff @(posedge clk) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  assign strobe.anyHit = |eligible;
  assign strobe.primed = primed;

  // R2: both groups off leaves nothing to signal
  p_groups_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    (grpEnable == 2'b00) |-> !strobe.anyHit);

  // R6: a mask at the top level blocks every source
  p_full_mask_r6: assert property (@(posedge clk) disable iff (!rstN)
    (maskLvl == '0) |-> !strobe.anyHit);
endmodule

// File: rtl/hpp_datapath.sv
module hpp_datapath
  import hpp_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        eligible,
  input  logic [NUM_SRC*PRIO_W-1:0] levelPrio,
  input  strobe_t                   strobe,
  output logic                      outValid,
  output logic [ID_W-1:0]           outId,
  output logic [PRIO_W-1:0]         outPrio,
  output kind_e                     outKind
);
  localparam int LVLS   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int LEAVES = 1 << LVLS;

  cand_t node [1:2*LEAVES-1];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < NUM_SRC) begin : g_real
      assign node[LEAVES+i] = '{vld: eligible[i],
                                pr:  levelPrio[i*PRIO_W +: PRIO_W],
                                id:  ID_W'(i)};
    end else begin : g_pad
      assign node[LEAVES+i] = '{vld: 1'b0, pr: '1, id: ID_W'(i)};
    end
  end

  for (genvar k = 1; k < LEAVES; k++) begin : g_node
    assign node[k] = pickBetter(node[2*k], node[2*k+1]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outId    <= NONE_ID;
      outPrio  <= '1;
      outKind  <= KIND_NONE;
    end else begin
      outValid <= node[1].vld;
      outId    <= node[1].vld ? node[1].id : NONE_ID;
      outPrio  <= node[1].vld ? node[1].pr : '1;
      outKind  <= node[1].vld ? kindOf(node[1].id) : KIND_NONE;
    end
  end

  // R9: valid follows the control's hit strobe one edge later
  p_valid_lag_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.primed |-> (outValid == $past(strobe.anyHit)));

  // R7: the none result carries the reserved ID and kind
  p_none_id_r7: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outId == NONE_ID && outKind == KIND_NONE && outPrio == '1));

  // R8: a valid ID names a real source
  p_id_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outId < ID_W'(NUM_SRC)));

  // R2: the reported source was a candidate on the previous cycle
  p_winner_elig_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.primed && outValid) |-> (|(($past(eligible) >> outId) & NUM_SRC'(1))));
endmodule

// File: rtl/hpp_select.sv
module hpp_select
  import hpp_pkg::*;
#(
  parameter int NUM_SRC   = 64,
  parameter int PRIO_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   srcPending,
  input  logic [NUM_SRC-1:0]   srcEnable,
  input  logic [NUM_SRC-1:0]   srcGroup,
  input  logic [NUM_SRC*8-1:0] srcPrio,
  input  logic [1:0]           grpEnable,
  input  logic [7:0]           prioMask,
  output logic                 outValid,
  output logic [9:0]           outId,
  output logic [7:0]           outPrio,
  output logic [1:0]           outKind
);
  logic [NUM_SRC-1:0]        eligible;
  logic [NUM_SRC*PRIO_W-1:0] levelPrio;
  strobe_t                   strobe;
  kind_e                     kindQ;

  hpp_ctrl #(.NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .srcPending(srcPending), .srcEnable(srcEnable), .srcGroup(srcGroup),
    .srcPrio(srcPrio), .grpEnable(grpEnable), .prioMask(prioMask),
    .eligible(eligible), .levelPrio(levelPrio), .strobe(strobe)
  );

  hpp_datapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk(clk), .rstN(rstN),
    .eligible(eligible), .levelPrio(levelPrio), .strobe(strobe),
    .outValid(outValid), .outId(outId), .outPrio(outPrio), .outKind(kindQ)
  );

  assign outKind = kindQ;
endmodule

// File: tb/sim_hpp_select.sv
`timescale 1ns/1ps
module sim_hpp_select;
  localparam int N = 64;
  localparam logic [7:0] KEEP = 8'hF0;

  typedef struct packed {
    logic [63:0] pend;
    logic [63:0] en;
    logic [63:0] grp;
    logic [1:0]  ge;
    logic [7:0]  mask;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 2'b11, 8'hFF},
    '{64'h00FF_00FF_00FF_00FF, 64'hFFFF_0000_FFFF_0000, 64'h0F0F_0F0F_0F0F_0F0F, 2'b11, 8'hC0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_FFFF_0000_0000, 2'b10, 8'h80},
    '{64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 2'b11, 8'h00},
    '{64'hF000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b01, 8'hFF},
    '{64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h5555_5555_5555_5555, 2'b11, 8'h70}
  };

  logic clk = 1'b0;
  logic rstN;
  logic [N-1:0] srcPending, srcEnable, srcGroup;
  logic [N*8-1:0] srcPrio;
  logic [1:0] grpEnable;
  logic [7:0] prioMask;
  logic outValid;
  logic [9:0] outId;
  logic [7:0] outPrio;
  logic [1:0] outKind;
  logic [7:0] prio [N];

  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  always_comb for (int i = 0; i < N; i++) srcPrio[i*8 +: 8] = prio[i];

  hpp_select #(.NUM_SRC(N), .PRIO_BITS(4)) u0 (
    .clk(clk), .rstN(rstN), .srcPending(srcPending), .srcEnable(srcEnable),
    .srcGroup(srcGroup), .srcPrio(srcPrio), .grpEnable(grpEnable),
    .prioMask(prioMask), .outValid(outValid), .outId(outId),
    .outPrio(outPrio), .outKind(outKind)
  );

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int kindFor(int id, bit v);
    if (!v) return 3;
    if (id < 16) return 0;
    if (id < 32) return 1;
    return 2;
  endfunction

  task automatic expectOut(string req, bit v, int id, int pr);
    chk(req, "valid", int'(outValid), int'(v));
    chk(req, "id", int'(outId), v ? id : 1023);
    chk(req, "prio", int'(outPrio), v ? pr : 255);
    chk(req, "kind", int'(outKind), kindFor(id, v));
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clearAll();
    srcPending = '0; srcEnable = '1; srcGroup = '0;
    grpEnable = 2'b11; prioMask = 8'hFF;
    for (int i = 0; i < N; i++) prio[i] = 8'hF0;
  endtask

  // linear-scan reference built from R2-R6
  task automatic refPick(output bit v, output int id, output int pr);
    v = 0; id = 1023; pr = 255;
    for (int i = 0; i < N; i++) begin
      int lv;
      lv = int'(prio[i] & KEEP);
      if (srcPending[i] && srcEnable[i] && grpEnable[srcGroup[i]] &&
          lv < int'(prioMask & KEEP)) begin
        if (!v || lv < pr) begin v = 1; id = i; pr = lv; end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    bit ev; int eid, epr;
    rstN = 1'b0;
    clearAll();
    srcPending = '1;
    prio[5] = 8'h00;
    step(); step(); step();
    expectOut("R1", 0, 0, 0);
    rstN = 1'b1;
    for (int i = 0; i < N; i++) prio[i] = 8'((i * 37 + 5) & 255);

    // R4 table walk against the reference
    for (int t = 0; t < 6; t++) begin
      srcPending = VECS[t].pend; srcEnable = VECS[t].en;
      srcGroup = VECS[t].grp; grpEnable = VECS[t].ge; prioMask = VECS[t].mask;
      step();
      refPick(ev, eid, epr);
      expectOut("R4", ev, eid, epr);
    end

    // R3 R5 R10: higher ID has smaller raw value but same level
    clearAll();
    prio[10] = 8'h8F; prio[20] = 8'h81;
    srcPending[10] = 1; srcPending[20] = 1;
    step();
    expectOut("R3", 1, 10, 8'h80);
    chk("R10", "low bits zero", int'(outPrio[3:0]), 0);

    // R5 exact tie
    clearAll();
    prio[33] = 8'h30; prio[50] = 8'h30;
    srcPending[33] = 1; srcPending[50] = 1;
    step();
    expectOut("R5", 1, 33, 8'h30);

    // R6 strict mask compare on truncated levels
    clearAll();
    prio[7] = 8'h40; srcPending[7] = 1; prioMask = 8'h40;
    step();
    expectOut("R6", 0, 0, 0);
    prioMask = 8'h4F;
    step();
    expectOut("R6", 0, 0, 0);
    prioMask = 8'h50;
    step();
    expectOut("R6", 1, 7, 8'h40);

    // R2 group and enable gating
    clearAll();
    prio[3] = 8'h10; prio[40] = 8'h20;
    srcPending[3] = 1; srcPending[40] = 1; srcGroup[3] = 1;
    grpEnable = 2'b01;
    step();
    expectOut("R2", 1, 40, 8'h20);
    grpEnable = 2'b11;
    step();
    expectOut("R2", 1, 3, 8'h10);
    srcEnable[3] = 0;
    step();
    expectOut("R2", 1, 40, 8'h20);
    grpEnable = 2'b10;
    step();
    expectOut("R7", 0, 0, 0);

    // R8 range kinds at the boundaries
    foreach (VECS[j]) begin end
    begin
      int ids [5] = '{15, 16, 31, 32, 63};
      for (int k = 0; k < 5; k++) begin
        clearAll();
        prio[ids[k]] = 8'h20; srcPending[ids[k]] = 1;
        step();
        expectOut("R8", 1, ids[k], 8'h20);
      end
    end

    // R9 latency: unchanged just after the input change, new after the edge
    clearAll();
    prio[0] = 8'h10; srcPending[0] = 1;
    #1;
    chk("R9", "before edge id", int'(outId), 63);
    step();
    expectOut("R9", 1, 0, 8'h10);

    // R7 nothing pending
    srcPending = '0;
    step();
    expectOut("R7", 0, 0, 0);

    // R1 reset in the middle of activity
    srcPending[0] = 1;
    step();
    rstN = 1'b0;
    step();
    expectOut("R1", 0, 0, 0);
    rstN = 1'b1;
    step();
    expectOut("R1", 1, 0, 8'h10);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule